// File: doc/BRIEF.md
# Two-Byte-Offset FRU Data Target on I2C

This block sits on a two-wire management bus and answers at one fixed 7-bit target address as if it were a serial EEPROM holding the card's field-replaceable-unit data. The host selects a 16-bit byte offset by addressing the block for writing and sending two bytes, least-significant first. It then issues a repeated START, addresses the block for reading, and clocks out as many bytes as it wants. The block returns the stored byte at the current pointer and advances the pointer after each byte the host acknowledges. It closes the read when the host NACKs.

The stored image is a fixed, computed table of `FRU_LEN` bytes. Bytes requested past the end of the table read as 0xFF. One read transaction delivers at most 256 real bytes; every byte after that in the same transaction is also 0xFF. A longer image is fetched with several offset-write and read pairs. SCL and SDA are sampled on the fast system clock through synchronisers. The block only pulls SDA low and never holds SCL.

The controller is one state machine. It has these states:

- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ACK_W` and `ST_ACK_R`: the address is acknowledged for a write or for a read.
- `ST_OFS_LO`, `ST_ACK_LO`, `ST_OFS_HI` and `ST_ACK_HI`: the two offset bytes are received and acknowledged.
- `ST_SEND`: a data byte is shifted out.
- `ST_HOST_ACK`: the host's acknowledge bit is sampled.
- `ST_IGNORE`: the block waits for the next START or STOP.

Transitions:

- A STOP goes to `ST_IDLE` from any state.
- A START, including a repeated START, goes to `ST_ADDR` from any state.
- At the SCL fall after the eighth address bit, the machine goes to `ST_ACK_W` or `ST_ACK_R` on a match and to `ST_IGNORE` otherwise.
- At each following SCL fall, the path runs `ST_ACK_W` to `ST_OFS_LO` to `ST_ACK_LO` to `ST_OFS_HI` to `ST_ACK_HI` to `ST_IGNORE`.
- `ST_ACK_R` goes to `ST_SEND`.
- `ST_SEND` goes to `ST_HOST_ACK` after eight bits.
- `ST_HOST_ACK` returns to `ST_SEND` if the host acknowledged, and goes to `ST_IGNORE` on a NACK.

Top module: `fru_eeprom_target`

## Requirements
- R1: The block acknowledges only 7-bit address 0x50 (wire byte 0xA0 to write, 0xA1 to read). Any other address gets no acknowledge, and SDA stays released.
- R2: After 0xA0, the block acknowledges two data bytes: first the offset low byte, then the offset high byte. The pointer takes the new 16-bit value when the high byte completes.
- R3: After a repeated START and 0xA1, the block acknowledges and sends the byte at the pointer, most-significant bit first. The byte at index i is `fru_byte(i)` from the package.
- R4: The pointer advances by one after every data byte the host acknowledges. On a host NACK, the block releases SDA for the rest of the transaction, and the NACKed byte does not advance the pointer.
- R5: A byte at a pointer value of `FRU_LEN` (300) or more reads as 0xFF. From offset 256, a 256-byte read gives 44 stored bytes, then 212 bytes of 0xFF.
- R6: At most 256 bytes per read transaction come from storage. Later bytes in the same transaction read as 0xFF, and the pointer stops advancing.
- R7: After reset the pointer is 0. A read with no offset write before it continues from the current pointer.
- R8: A STOP after only the low offset byte leaves the pointer unchanged.
- R9: SDA is released after reset and after a STOP, and the block changes its SDA drive only while SCL is low.
- R10: Any data byte written after the two offset bytes gets no acknowledge and does not change the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest state to reach is the 256-byte cap with stored data still left. The pointer must run a full 256 bytes in one transaction and still be below `FRU_LEN`, so the padding comes from the cap rather than from the end of the table. The bench sets the offset to 0 and reads 258 bytes in one transaction; the last two must be 0xFF even though bytes 256 and 257 exist in storage. The pointer rules between transactions are also hard to see from the pins: NACK without advance, a half-written offset, and an extra written byte. These are observed only through the first byte of the next read with no offset write.

// File: rtl/fru_pkg.sv
package fru_pkg;

    localparam int          FRU_LEN_DEF  = 300;
    localparam int          XFER_MAX_DEF = 256;
    localparam logic [6:0]  TGT_ADDR_DEF = 7'h50;
    localparam int          PTR_W        = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_W,
        ST_ACK_R,
        ST_OFS_LO,
        ST_ACK_LO,
        ST_OFS_HI,
        ST_ACK_HI,
        ST_SEND,
        ST_HOST_ACK,
        ST_IGNORE
    } tgt_state_t;

    // Contents of the emulated FRU image, computed per index.
    function automatic logic [7:0] fru_byte(input logic [PTR_W-1:0] idx);
        logic [7:0] mix;
        mix = idx[7:0] * 8'd37;
        return (mix + 8'd11) ^ {5'b0, idx[10:8]};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/fru_store.sv
module fru_store #(
    parameter int LEN = 300,
    parameter int AW  = 16
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_data
);
    localparam logic [AW-1:0] LEN_V = AW'(LEN);

    always_ff @(posedge clk) begin
        if (addr < LEN_V) rd_data <= fru_pkg::fru_byte(addr);
        else              rd_data <= 8'hFF;
    end

endmodule

// File: rtl/fru_eeprom_target.sv
module fru_eeprom_target
    import fru_pkg::*;
#(
    parameter int         FRU_LEN     = FRU_LEN_DEF,
    parameter int         XFER_MAX    = XFER_MAX_DEF,
    parameter logic [6:0] TGT_ADDR    = TGT_ADDR_DEF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int             CNT_W = $clog2(XFER_MAX + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(XFER_MAX);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    tgt_state_t       state, nxt;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [7:0]       lo_hold;
    logic [7:0]       tx;
    logic [PTR_W-1:0] ptr;
    logic [CNT_W-1:0] xfer_cnt;
    logic             host_acked;
    logic [7:0]       rom_data;
    logic [7:0]       pick;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    fru_store #(.LEN(FRU_LEN), .AW(PTR_W)) u_store (
        .clk    (clk),
        .addr   (ptr),
        .rd_data(rom_data)
    );

    assign pick = (xfer_cnt >= CAP) ? 8'hFF : rom_data;

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall && bit_cnt == 4'd8) begin
                        if (shreg[7:1] == TGT_ADDR) nxt = shreg[0] ? ST_ACK_R : ST_ACK_W;
                        else                        nxt = ST_IGNORE;
                    end
                end
                ST_ACK_W:    if (scl_fall) nxt = ST_OFS_LO;
                ST_OFS_LO:   if (scl_fall && bit_cnt == 4'd8) nxt = ST_ACK_LO;
                ST_ACK_LO:   if (scl_fall) nxt = ST_OFS_HI;
                ST_OFS_HI:   if (scl_fall && bit_cnt == 4'd8) nxt = ST_ACK_HI;
                ST_ACK_HI:   if (scl_fall) nxt = ST_IGNORE;
                ST_ACK_R:    if (scl_fall) nxt = ST_SEND;
                ST_SEND:     if (scl_fall && bit_cnt == 4'd7) nxt = ST_HOST_ACK;
                ST_HOST_ACK: if (scl_fall) nxt = host_acked ? ST_SEND : ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            lo_hold    <= '0;
            tx         <= 8'hFF;
            ptr        <= '0;
            xfer_cnt   <= '0;
            host_acked <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det) begin
                bit_cnt  <= '0;
                xfer_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_OFS_LO, ST_OFS_HI: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall && bit_cnt == 4'd8) begin
                            if (state == ST_OFS_LO) lo_hold <= shreg;
                            if (state == ST_OFS_HI) ptr     <= {shreg, lo_hold};
                        end
                    end
                    ST_ACK_W, ST_ACK_LO: if (scl_fall) bit_cnt <= '0;
                    ST_ACK_R: begin
                        if (scl_fall) begin
                            tx      <= pick;
                            bit_cnt <= '0;
                        end
                    end
                    ST_SEND: begin
                        if (scl_fall) begin
                            tx      <= {tx[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    ST_HOST_ACK: begin
                        if (scl_rise) begin
                            host_acked <= ~sda_s;
                            if (!sda_s && xfer_cnt < CAP) begin
                                ptr      <= ptr + 1'b1;
                                xfer_cnt <= xfer_cnt + 1'b1;
                            end
                        end
                        if (scl_fall && host_acked) begin
                            tx      <= pick;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output logic
    always_comb begin
        unique case (state)
            ST_ACK_W, ST_ACK_R, ST_ACK_LO, ST_ACK_HI: sda_oe = 1'b1;
            ST_SEND:                                 sda_oe = ~tx[7];
            default:                                 sda_oe = 1'b0;
        endcase
    end

    // R9: drive changes only while SCL is low
    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9: STOP leaves SDA released
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4/R2: pointer moves only by one after a host ack, or by offset commit
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> (($past(state) == ST_HOST_ACK) && (ptr == $past(ptr) + 16'd1))
                          || ($past(state) == ST_OFS_HI));

    // R6: once the cap is reached the pointer holds until the next START
    a_r6_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cnt == CAP && !start_det) |=> $stable(ptr));

    // R8: STOP during the high offset byte does not move the pointer
    a_r8_half_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && state == ST_OFS_HI) |=> $stable(ptr));

endmodule

// File: tb/fru_eeprom_target_tb.sv
module fru_eeprom_target_tb;
    import fru_pkg::*;

    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_lo = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;

    always #4 clk = ~clk;

    assign sda_line = ~(m_sda_lo | sda_oe);

    fru_eeprom_target u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (m_scl),
        .sda_i (sda_line),
        .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_lo = 1'b0; wq(Q);
        m_scl = 1'b1;    wq(2*Q);
        m_sda_lo = 1'b1; wq(2*Q);
        m_scl = 1'b0;    wq(Q);
    endtask

    task automatic bus_stop();
        wq(Q); m_sda_lo = 1'b1;
        wq(Q); m_scl = 1'b1;
        wq(2*Q); m_sda_lo = 1'b0;
        wq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        wq(Q); m_sda_lo = ~b;
        wq(Q); m_scl = 1'b1;
        wq(2*Q); m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wq(Q); m_sda_lo = 1'b0;
        wq(Q); m_scl = 1'b1;
        wq(Q); b = sda_line;
        wq(Q); m_scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack_lvl);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(ack_lvl);
    endtask

    task automatic get_byte(input logic do_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~do_ack);
    endtask

    function automatic logic [7:0] expect_at(input int p, input int k);
        if (k >= 256) return 8'hFF;
        if (p + k >= 300) return 8'hFF;
        return fru_byte(16'(p + k));
    endfunction

    task automatic write_offset(input logic [15:0] ofs);
        logic a;
        bus_start();
        put_byte(8'hA0, a); chk("R1 addr 0x50 write ack", a, 0);
        put_byte(ofs[7:0], a); chk("R2 low offset ack", a, 0);
        put_byte(ofs[15:8], a); chk("R2 high offset ack", a, 0);
    endtask

    task automatic check_read(input int p, input int n, input string req);
        logic       a;
        logic [7:0] d;
        bus_start();
        put_byte(8'hA1, a); chk("R3 read address ack", a, 0);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, d);
            chk(req, d, expect_at(p, k));
        end
        wq(2);
        chk("R4 SDA released after NACK", sda_oe, 0);
        bus_stop();
        chk("R9 released after STOP", sda_oe, 0);
    endtask

    task automatic t_reset();
        chk("R9 reset SDA released", sda_oe, 0);
        check_read(0, 3, "R7 read from reset pointer");
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        put_byte(8'hA2, a); chk("R1 0x51 write no ack", a, 1);
        bus_stop();
        bus_start();
        put_byte(8'h6F, a); chk("R1 0x37 read no ack", a, 1);
        bus_stop();
        check_read(2, 1, "R1 pointer untouched by foreign address");
    endtask

    task automatic t_offset_read();
        write_offset(16'h0010);
        check_read(16, 4, "R3 data from offset 0x10");
    endtask

    task automatic t_continue();
        check_read(19, 2, "R7 continue without offset write");
    endtask

    task automatic t_half_offset();
        logic a;
        bus_start();
        put_byte(8'hA0, a); chk("R1 ack", a, 0);
        put_byte(8'h55, a); chk("R2 low byte ack", a, 0);
        bus_stop();
        check_read(20, 1, "R8 pointer kept after half offset");
    endtask

    task automatic t_extra_byte();
        logic a;
        write_offset(16'h0005);
        put_byte(8'h77, a); chk("R10 third byte not acked", a, 1);
        bus_stop();
        check_read(5, 2, "R10 pointer from committed offset");
    endtask

    task automatic t_tail();
        write_offset(16'd296);
        check_read(296, 6, "R5 end of image pads 0xFF");
    endtask

    task automatic t_cap();
        write_offset(16'd0);
        check_read(0, 258, "R6 per-transaction cap");
    endtask

    task automatic t_second_chunk();
        write_offset(16'd256);
        check_read(256, 256, "R5 second chunk 44 data then pad");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_bad_addr();
        t_offset_read();
        t_continue();
        t_half_offset();
        t_extra_byte();
        t_tail();
        t_cap();
        t_second_chunk();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule